// File: doc/BRIEF.md
# Codec PCM Serial Sample Receiver

This block talks to an external PCM codec of the telephony kind. From one master clock it makes the two clocks the codec needs. The bit clock is the master clock divided by 16. The frame sync marks the start of every 32-bit frame. The block also shifts in the serial samples that the codec sends back on its data line.

Each frame carries an 8-bit signed companded sample at its start. The block drops the sign bit and keeps only the size of the sample. It outputs that as an unsigned 8-bit magnitude word, with a strobe one master cycle long. A downstream stage, such as a noise-level integrator, can add up these words without caring about sign. Companding expansion and codec setup are done elsewhere.

Top module: `pcm_rx`

## Requirements
- R1: The bit clock output has a period of 16 master clock cycles. It is high for 8 cycles and low for 8 cycles. It is high straight after reset.
- R2: The frame sync output repeats every 32 bit-clock periods. It rises together with a bit-clock rising edge and stays high for exactly one bit-clock period.
- R3: The data line is sampled at the master edge where the bit clock falls. Sampling happens in the 8 bit periods that begin with the period in which frame sync is high. The first bit received is the most significant bit.
- R4: The received byte is b7..b0, with b7 received first. Bit b7 is the sign and is discarded. The magnitude word is {b6..b0, 0}, so it runs from 00 to FE.
- R5: The valid strobe is high for exactly one master cycle per frame. It rises in the master cycle right after the eighth bit is sampled, which is while the bit clock is low in bit period 7. The magnitude word changes only together with the strobe.
- R6: While reset is low, the outputs are as follows: the bit clock and frame sync are high, the magnitude word is 00 and the strobe is low. The first frame begins when reset is released. A reset in the middle of a frame restarts the frame timing.
- R7: Data line activity in bit periods 8 through 31 has no effect on the magnitude word or on the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sdin | input | 1 | Serial sample data from the codec |
| bclk | output | 1 | Bit clock to the codec |
| fsync | output | 1 | Frame sync to the codec |
| mag | output | 8 | Unsigned magnitude of the last sample |
| mag_vld | output | 1 | One-cycle strobe for a new magnitude |

## Verification
The assertions check the clock timing on every cycle. They check that the bit clock changes every 8 master cycles and that frame sync starts and ends on bit-clock rising edges. They check that the strobe lasts one cycle, falls in the low half of the bit clock outside the sync period, and always comes with a zero LSB. They also check that the magnitude word stays still when there is no strobe. Only the bench scenarios can show the rest: the data bit order, that the sign bit is dropped, the exact magnitude values, the 32-period frame length, and that late-frame data is ignored. These need known serial patterns to be driven and compared.

// File: rtl/pcm_rx.sv
module pcm_rx #(
  parameter int BCLK_DIV    = 16,
  parameter int FRAME_BITS  = 32,
  parameter int SAMPLE_BITS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sdin,
  output logic                   bclk,
  output logic                   fsync,
  output logic [SAMPLE_BITS-1:0] mag,
  output logic                   mag_vld
);
  localparam int HALF = BCLK_DIV / 2;
  localparam int MW   = $clog2(BCLK_DIV);
  localparam int FW   = $clog2(FRAME_BITS);

  logic [MW-1:0]          mcnt;
  logic [FW-1:0]          bcnt;
  logic [SAMPLE_BITS-2:0] hist;

  wire mwrap  = (mcnt == MW'(BCLK_DIV - 1));
  wire bwrap  = (bcnt == FW'(FRAME_BITS - 1));
  wire smp    = (mcnt == MW'(HALF - 1));
  wire in_win = (bcnt < FW'(SAMPLE_BITS));
  wire lastb  = (bcnt == FW'(SAMPLE_BITS - 1));

  assign bclk  = (mcnt < MW'(HALF));
  assign fsync = (bcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcnt <= '0;
      bcnt <= '0;
    end else begin
      mcnt <= mwrap ? '0 : mcnt + 1'b1;
      if (mwrap) bcnt <= bwrap ? '0 : bcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist    <= '0;
      mag     <= '0;
      mag_vld <= 1'b0;
    end else begin
      mag_vld <= 1'b0;
      if (smp && in_win) begin
        hist <= {hist[SAMPLE_BITS-3:0], sdin};
        if (lastb) begin
          mag     <= {hist[SAMPLE_BITS-3:0], sdin, 1'b0};
          mag_vld <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_rx_chk.sv
module pcm_rx_chk #(
  parameter int BCLK_DIV    = 16,
  parameter int SAMPLE_BITS = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bclk,
  input logic                   fsync,
  input logic [SAMPLE_BITS-1:0] mag,
  input logic                   mag_vld
);
  localparam int HALF = BCLK_DIV / 2;
  localparam int CW   = $clog2(BCLK_DIV);

  logic [CW-1:0] run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else        run <= (run == CW'(HALF - 1)) ? '0 : run + 1'b1;
  end

  p_bclk_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run == CW'(HALF - 1)) |=> (bclk != $past(bclk)));
  p_bclk_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run != CW'(HALF - 1)) |=> $stable(bclk));
  p_fsync_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync) |-> $rose(bclk));
  p_fsync_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fsync) |-> $rose(bclk));
  p_vld_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mag_vld |=> !mag_vld);
  p_vld_place_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mag_vld |-> (!bclk && !fsync));
  p_mag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mag_vld |-> $stable(mag));
  p_mag_lsb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mag_vld |-> (mag[0] == 1'b0));
endmodule

bind pcm_rx pcm_rx_chk #(.BCLK_DIV(BCLK_DIV), .SAMPLE_BITS(SAMPLE_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .mag(mag), .mag_vld(mag_vld)
);

// File: tb/sim_pcm_rx.sv
module sim_pcm_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sdin = 1'b0;
  logic bclk, fsync, mag_vld;
  logic [7:0] mag;
  int checks = 0;
  int errors = 0;
  int vcount = 0;

  always #4 clk = ~clk;

  pcm_rx u0 (.clk(clk), .rst_n(rst_n), .sdin(sdin), .bclk(bclk),
             .fsync(fsync), .mag(mag), .mag_vld(mag_vld));

  always @(posedge clk) if (rst_n && mag_vld) vcount++;

  localparam logic [15:0] VEC [8] = '{
    16'h00_00, 16'hFF_FE, 16'h80_00, 16'h7F_FE,
    16'h55_AA, 16'hAA_54, 16'hC3_86, 16'h3C_78
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [7:0] b, input logic [7:0] exp, input logic junk);
    int c0 = vcount;
    sdin = b[7];
    for (int i = 6; i >= 0; i--) begin
      @(posedge bclk); #1;
      sdin = b[i];
    end
    @(posedge mag_vld); #1;
    chk("R4 magnitude", 32'(mag), 32'(exp));
    chk("R5 strobe high", 32'(mag_vld), 32'd1);
    @(posedge clk); #1;
    chk("R5 strobe one cycle", 32'(mag_vld), 32'd0);
    forever begin
      @(posedge bclk); #1;
      if (fsync) break;
      sdin = junk ? ~sdin : 1'b0;
    end
    chk("R7 late bits ignored", 32'(mag), 32'(exp));
    chk("R5 one strobe per frame", 32'(vcount - c0), 32'd1);
  endtask

  initial begin
    int n;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R6 reset bclk", 32'(bclk), 32'd1);
    chk("R6 reset fsync", 32'(fsync), 32'd1);
    chk("R6 reset mag", 32'(mag), 32'd0);
    chk("R6 reset strobe", 32'(mag_vld), 32'd0);
    rst_n = 1'b1;

    @(negedge bclk); #1;
    n = 0;
    while (!bclk) begin @(posedge clk); #1; n++; end
    chk("R1 bclk low cycles", 32'(n), 32'd8);
    n = 0;
    while (bclk) begin @(posedge clk); #1; n++; end
    chk("R1 bclk high cycles", 32'(n), 32'd8);

    @(posedge fsync); #1;
    n = 0;
    do begin
      @(posedge bclk); #1;
      n++;
      if (n == 1) chk("R2 sync one period", 32'(fsync), 32'd0);
    end while (!fsync);
    chk("R2 frame length", 32'(n), 32'd32);

    // R3 R4 R5 R7: table of sample patterns, MSB first
    for (int i = 0; i < 8; i++)
      send_frame(VEC[i][15:8], VEC[i][7:0], i[0]);

    // R3: bit order, single set bit at each position
    for (int k = 0; k < 7; k++)
      send_frame(8'(1 << k), 8'(1 << (k + 1)), 1'b1);

    // R6: reset in the middle of a frame
    repeat (100) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R6 mid reset mag", 32'(mag), 32'd0);
    chk("R6 mid reset fsync", 32'(fsync), 32'd1);
    chk("R6 mid reset bclk", 32'(bclk), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    send_frame(8'h66, 8'hCC, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule